// File: doc/BRIEF.md
# Indirect Configuration Register Window

This block holds the configuration and error registers of an external bus controller. Software cannot reach these registers directly. Instead, two device-control-register numbers are decoded. One is a pointer register, which stores an index. The other is a data window, whose reads return the internal word that the stored pointer selects. The internal words are eight bank setup words, eight bank timing words, an error address word, two error status words and a global setup word. The map is sparse: indices that select nothing read as zero.

Bus-error hardware reports through a capture strobe. The strobe carries an address and a status value. The first error is latched into the error address word and the first error status word, and it stays there until reset. Later errors are dropped. Every read and every write on the control interface is acknowledged one cycle after its strobe. Read data is registered and is valid in the acknowledge cycle.

Top module: `xbc_cfg_window`

## Requirements
- R1: A write to register number 0x012 stores all 32 bits of the written value as the pointer, and a read of 0x012 returns the stored pointer.
- R2: A read of register number 0x013 returns the selected word. Pointer 0x00+k selects bank setup word k, and pointer 0x10+k selects bank timing word k, for k = 0 to 7. All of these words read as zero.
- R3: Through 0x013, pointer 0x20 selects the error address word, 0x21 the first error status word, 0x22 the second error status word (always zero), and 0x23 the global setup word.
- R4: Only pointer bits 5:0 select a word. A pointer whose bits 31:6 are not all zero reads as zero, and so does any pointer value in 0x00..0x3F that matches none of the words in R2 or R3.
- R5: A read of any register number other than 0x012 or 0x013 returns zero. A write to such a number changes no state.
- R6: A write through 0x013 changes no internal word, whatever the pointer selects.
- R7: After reset the pointer, the error words and all bank words are zero, and the global setup word is 0x80400000.
- R8: When cap_valid is high at a clock edge and both the error address word and the first error status word are zero, the two words load cap_addr and cap_status at that edge.
- R9: Once either captured word is non-zero, further captures are ignored until reset.
- R10: dcr_ack is high exactly one cycle after any cycle with dcr_rd or dcr_wr high. dcr_rdata carries the read result in that cycle and is zero in every cycle that does not follow a read. If a read and a write occur in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dcr_rd | input | 1 | Read strobe |
| dcr_wr | input | 1 | Write strobe |
| dcr_num | input | 10 | Register number |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Registered read data |
| dcr_ack | output | 1 | Acknowledge, one cycle after a strobe |
| cap_valid | input | 1 | Bus error capture strobe |
| cap_addr | input | 32 | Address of the failing access |
| cap_status | input | 32 | Status of the failing access |

## Verification
Most internal state is visible only through the window. A corrupted pointer therefore shows up on the first data-window read after the bad write, one cycle after that read's strobe. A latch that loses the first error, or lets a second error overwrite it, shows up on the next read of pointer 0x20 or 0x21. A decode slip that maps a hole, a high pointer or a foreign register number onto a live word returns non-zero data where zero is expected. Broken acknowledge timing shows in the cycle right after a strobe.

// File: rtl/xbc_cfg_pkg.sv
package xbc_cfg_pkg;
   localparam int unsigned SEL_W = 6;

   typedef enum logic [1:0] {
      RGN_BANK_SETUP  = 2'd0,
      RGN_BANK_TIMING = 2'd1,
      RGN_ERROR       = 2'd2,
      RGN_HOLE        = 2'd3
   } region_e;

   // Upper selector bits choose a 16-word region of the window.
   function automatic region_e region_of(input logic [SEL_W-1:0] sel);
      case (sel[SEL_W-1:4])
         2'b00:   return RGN_BANK_SETUP;
         2'b01:   return RGN_BANK_TIMING;
         2'b10:   return RGN_ERROR;
         default: return RGN_HOLE;
      endcase
   endfunction
endpackage

// File: rtl/xbc_bank_table.sv
module xbc_bank_table #(
   parameter int unsigned BANKS = 8,
   parameter int unsigned DW    = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   output logic [BANKS-1:0][DW-1:0] setup_q,
   output logic [BANKS-1:0][DW-1:0] timing_q
);
   // The words have no write path, so they keep their reset value.
   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            setup_q[b]  <= '0;
            timing_q[b] <= '0;
         end
      end
   end

   a_r6_banks_stay_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_q == '0) && (timing_q == '0));
endmodule

// File: rtl/xbc_err_capture.sv
module xbc_err_capture #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_valid,
   input  logic [DW-1:0] cap_addr,
   input  logic [DW-1:0] cap_status,
   output logic [DW-1:0] err_addr_q,
   output logic [DW-1:0] err_stat0_q,
   output logic [DW-1:0] err_stat1_q
);
   logic armed;
   assign armed = (err_addr_q == '0) && (err_stat0_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_addr_q  <= '0;
         err_stat0_q <= '0;
         err_stat1_q <= '0;
      end else if (cap_valid && armed) begin
         err_addr_q  <= cap_addr;
         err_stat0_q <= cap_status;
      end
   end

   a_r8_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && err_addr_q == '0 && err_stat0_q == '0)
      |=> (err_addr_q == $past(cap_addr)) && (err_stat0_q == $past(cap_status)));

   a_r9_first_error_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (err_addr_q != '0 || err_stat0_q != '0)
      |=> $stable(err_addr_q) && $stable(err_stat0_q));

   a_r3_second_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
      err_stat1_q == '0);
endmodule

// File: rtl/xbc_window_mux.sv
module xbc_window_mux
   import xbc_cfg_pkg::*;
#(
   parameter int unsigned BANKS = 8,
   parameter int unsigned DW    = 32
) (
   input  logic [DW-1:0]            ptr,
   input  logic [BANKS-1:0][DW-1:0] setup_q,
   input  logic [BANKS-1:0][DW-1:0] timing_q,
   input  logic [DW-1:0]            err_addr_q,
   input  logic [DW-1:0]            err_stat0_q,
   input  logic [DW-1:0]            err_stat1_q,
   input  logic [DW-1:0]            gcfg_q,
   output logic [DW-1:0]            win_data
);
   logic [SEL_W-1:0] sel;
   logic             ptr_high;
   logic [3:0]       off;
   region_e          rgn;

   assign sel      = ptr[SEL_W-1:0];
   assign ptr_high = |ptr[DW-1:SEL_W];
   assign off      = sel[3:0];
   assign rgn      = region_of(sel);

   always_comb begin
      win_data = '0;
      if (!ptr_high) begin
         unique case (rgn)
            RGN_BANK_SETUP: begin
               for (int b = 0; b < int'(BANKS); b++)
                  if (int'(off) == b) win_data = setup_q[b];
            end
            RGN_BANK_TIMING: begin
               for (int b = 0; b < int'(BANKS); b++)
                  if (int'(off) == b) win_data = timing_q[b];
            end
            RGN_ERROR: begin
               case (off)
                  4'h0:    win_data = err_addr_q;
                  4'h1:    win_data = err_stat0_q;
                  4'h2:    win_data = err_stat1_q;
                  4'h3:    win_data = gcfg_q;
                  default: win_data = '0;
               endcase
            end
            default: win_data = '0;
         endcase
      end
   end

   always_comb begin
      a_r4_high_ptr_zero: assert (!ptr_high || win_data == '0);
   end
endmodule

// File: rtl/xbc_cfg_window.sv
module xbc_cfg_window #(
   parameter int unsigned          DW         = 32,
   parameter int unsigned          NUM_W      = 10,
   parameter int unsigned          BANKS      = 8,
   parameter logic [NUM_W-1:0]     PTR_NUM    = 10'h012,
   parameter logic [NUM_W-1:0]     WIN_NUM    = 10'h013,
   parameter logic [DW-1:0]        GCFG_RESET = 32'h8040_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dcr_rd,
   input  logic             dcr_wr,
   input  logic [NUM_W-1:0] dcr_num,
   input  logic [DW-1:0]    dcr_wdata,
   output logic [DW-1:0]    dcr_rdata,
   output logic             dcr_ack,
   input  logic             cap_valid,
   input  logic [DW-1:0]    cap_addr,
   input  logic [DW-1:0]    cap_status
);
   localparam int unsigned MIN_DW = xbc_cfg_pkg::SEL_W + 1;

   if (BANKS < 1 || BANKS > 16) begin : g_bad_banks
      $error("BANKS must lie in 1..16");
   end
   if (DW < MIN_DW) begin : g_bad_dw
      $error("DW too narrow for the selector");
   end
   if (PTR_NUM == WIN_NUM) begin : g_bad_nums
      $error("pointer and window numbers must differ");
   end

   logic [DW-1:0]            ptr_q;
   logic [DW-1:0]            gcfg_q;
   logic [BANKS-1:0][DW-1:0] setup_q;
   logic [BANKS-1:0][DW-1:0] timing_q;
   logic [DW-1:0]            err_addr_q;
   logic [DW-1:0]            err_stat0_q;
   logic [DW-1:0]            err_stat1_q;
   logic [DW-1:0]            win_data;
   logic [DW-1:0]            rd_value;

   // Pointer register: the only state software can write.
   always_ff @(posedge clk) begin
      if (!rst_n)                          ptr_q <= '0;
      else if (dcr_wr && dcr_num == PTR_NUM) ptr_q <= dcr_wdata;
   end

   // Global setup word has no write path.
   always_ff @(posedge clk) begin
      if (!rst_n) gcfg_q <= GCFG_RESET;
   end

   xbc_bank_table #(.BANKS(BANKS), .DW(DW)) u_banks (
      .clk      (clk),
      .rst_n    (rst_n),
      .setup_q  (setup_q),
      .timing_q (timing_q)
   );

   xbc_err_capture #(.DW(DW)) u_err (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_valid   (cap_valid),
      .cap_addr    (cap_addr),
      .cap_status  (cap_status),
      .err_addr_q  (err_addr_q),
      .err_stat0_q (err_stat0_q),
      .err_stat1_q (err_stat1_q)
   );

   xbc_window_mux #(.BANKS(BANKS), .DW(DW)) u_mux (
      .ptr         (ptr_q),
      .setup_q     (setup_q),
      .timing_q    (timing_q),
      .err_addr_q  (err_addr_q),
      .err_stat0_q (err_stat0_q),
      .err_stat1_q (err_stat1_q),
      .gcfg_q      (gcfg_q),
      .win_data    (win_data)
   );

   always_comb begin
      if (dcr_num == PTR_NUM)      rd_value = ptr_q;
      else if (dcr_num == WIN_NUM) rd_value = win_data;
      else                         rd_value = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dcr_rdata <= '0;
         dcr_ack   <= 1'b0;
      end else begin
         dcr_rdata <= dcr_rd ? rd_value : '0;
         dcr_ack   <= dcr_rd | dcr_wr;
      end
   end

   a_r10_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (dcr_rd || dcr_wr) |=> dcr_ack);

   a_r10_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !(dcr_rd || dcr_wr) |=> !dcr_ack);

   a_r10_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dcr_rd |=> dcr_rdata == '0);

   a_r1_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(dcr_wr && dcr_num == PTR_NUM) |=> $stable(ptr_q));

   a_r7_gcfg_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      gcfg_q == GCFG_RESET);
endmodule

// File: tb/xbc_cfg_window_bench.sv
module xbc_cfg_window_bench;
   localparam int CLK_P = 10;
   localparam logic [9:0] PTR = 10'h012;
   localparam logic [9:0] WIN = 10'h013;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dcr_rd = 1'b0, dcr_wr = 1'b0;
   logic [9:0]  dcr_num = '0;
   logic [31:0] dcr_wdata = '0;
   logic [31:0] dcr_rdata;
   logic        dcr_ack;
   logic        cap_valid = 1'b0;
   logic [31:0] cap_addr = '0, cap_status = '0;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   xbc_cfg_window u_xbc_cfg_window (
      .clk(clk), .rst_n(rst_n), .dcr_rd(dcr_rd), .dcr_wr(dcr_wr),
      .dcr_num(dcr_num), .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata),
      .dcr_ack(dcr_ack), .cap_valid(cap_valid), .cap_addr(cap_addr),
      .cap_status(cap_status)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_write(input logic [9:0] num, input logic [31:0] val);
      @(negedge clk);
      dcr_wr = 1'b1; dcr_num = num; dcr_wdata = val;
      @(negedge clk);
      dcr_wr = 1'b0;
      check("R10 write ack", 32'(dcr_ack), 32'd1);
   endtask

   task automatic do_read(input logic [9:0] num, output logic [31:0] val);
      @(negedge clk);
      dcr_rd = 1'b1; dcr_num = num;
      @(negedge clk);
      dcr_rd = 1'b0;
      check("R10 read ack", 32'(dcr_ack), 32'd1);
      val = dcr_rdata;
   endtask

   task automatic win_read(input logic [31:0] p, output logic [31:0] val);
      do_write(PTR, p);
      do_read(WIN, val);
   endtask

   task automatic do_capture(input logic [31:0] a, input logic [31:0] s);
      @(negedge clk);
      cap_valid = 1'b1; cap_addr = a; cap_status = s;
      @(negedge clk);
      cap_valid = 1'b0;
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      check("R10 idle ack", 32'(dcr_ack), 32'd0);
      check("R10 idle rdata", dcr_rdata, 32'd0);
      do_read(PTR, v);
      check("R7 pointer reset", v, 32'd0);
      win_read(32'h23, v);
      check("R7 global setup reset", v, 32'h8040_0000);
      win_read(32'h20, v);
      check("R7 error address reset", v, 32'd0);
      win_read(32'h21, v);
      check("R7 error status reset", v, 32'd0);
   endtask

   task automatic t_pointer();
      logic [31:0] v;
      do_write(PTR, 32'hDEAD_BEEF);
      do_read(PTR, v);
      check("R1 pointer full width", v, 32'hDEAD_BEEF);
      do_write(PTR, 32'h0000_0001);
      do_read(PTR, v);
      check("R1 pointer rewrite", v, 32'h0000_0001);
   endtask

   task automatic t_banks();
      logic [31:0] v;
      for (int k = 0; k < 8; k++) begin
         win_read(32'(k), v);
         check("R2 bank setup word", v, 32'd0);
         win_read(32'(16 + k), v);
         check("R2 bank timing word", v, 32'd0);
      end
   endtask

   task automatic t_holes();
      logic [31:0] v;
      win_read(32'h63, v);
      check("R4 high pointer aliasing global word", v, 32'd0);
      win_read(32'h0000_0123, v);
      check("R4 high pointer bit 8", v, 32'd0);
      win_read(32'h24, v);
      check("R4 hole 0x24", v, 32'd0);
      win_read(32'h3F, v);
      check("R4 hole 0x3F", v, 32'd0);
      win_read(32'h08, v);
      check("R4 hole 0x08", v, 32'd0);
   endtask

   task automatic t_foreign();
      logic [31:0] v;
      do_write(PTR, 32'h23);
      do_read(10'h011, v);
      check("R5 foreign read 0x011", v, 32'd0);
      do_read(10'h014, v);
      check("R5 foreign read 0x014", v, 32'd0);
      do_write(10'h014, 32'hFFFF_FFFF);
      do_read(PTR, v);
      check("R5 foreign write leaves pointer", v, 32'h23);
      do_read(WIN, v);
      check("R5 foreign write leaves global word", v, 32'h8040_0000);
   endtask

   task automatic t_window_write();
      logic [31:0] v;
      do_write(PTR, 32'h23);
      do_write(WIN, 32'h1234_5678);
      do_read(WIN, v);
      check("R6 global word unchanged", v, 32'h8040_0000);
      do_read(PTR, v);
      check("R6 pointer unchanged", v, 32'h23);
      do_write(PTR, 32'h05);
      do_write(WIN, 32'hFFFF_FFFF);
      do_read(WIN, v);
      check("R6 bank word unchanged", v, 32'd0);
      do_write(PTR, 32'h20);
      do_write(WIN, 32'hAAAA_5555);
      do_read(WIN, v);
      check("R6 error address unchanged", v, 32'd0);
   endtask

   task automatic t_capture();
      logic [31:0] v;
      do_capture(32'hCAFE_0010, 32'h0000_00C3);
      win_read(32'h20, v);
      check("R8 captured address", v, 32'hCAFE_0010);
      win_read(32'h21, v);
      check("R8 captured status", v, 32'h0000_00C3);
      win_read(32'h22, v);
      check("R3 second status zero", v, 32'd0);
      do_capture(32'h1111_2222, 32'h3333_4444);
      win_read(32'h20, v);
      check("R9 address kept", v, 32'hCAFE_0010);
      win_read(32'h21, v);
      check("R9 status kept", v, 32'h0000_00C3);
      do_reset();
      win_read(32'h20, v);
      check("R9 cleared by reset", v, 32'd0);
      do_capture(32'h0000_0000, 32'h0000_0008);
      do_capture(32'h0000_0BAD, 32'h0000_0001);
      win_read(32'h20, v);
      check("R9 status alone blocks capture", v, 32'd0);
      win_read(32'h21, v);
      check("R8 status-only capture", v, 32'h0000_0008);
   endtask

   task automatic t_timing();
      do_write(PTR, 32'h0000_00AB);
      @(negedge clk);
      check("R10 no ack when idle", 32'(dcr_ack), 32'd0);
      @(negedge clk);
      dcr_rd = 1'b1; dcr_wr = 1'b1; dcr_num = PTR; dcr_wdata = 32'h0000_00CD;
      @(negedge clk);
      dcr_rd = 1'b0; dcr_wr = 1'b0;
      check("R10 combined ack", 32'(dcr_ack), 32'd1);
      check("R10 read sees old pointer", dcr_rdata, 32'h0000_00AB);
      @(negedge clk);
      check("R10 rdata zero after ack", dcr_rdata, 32'd0);
      check("R10 ack drops", 32'(dcr_ack), 32'd0);
      dcr_rd = 1'b1;
      @(negedge clk);
      dcr_rd = 1'b0;
      check("R1 pointer after combined write", dcr_rdata, 32'h0000_00CD);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      t_reset_state();
      t_pointer();
      t_banks();
      t_holes();
      t_foreign();
      t_window_write();
      t_capture();
      t_timing();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule